// File: doc/BRIEF.md
# GPIO Pin Event Detector

This block watches the 32 already-synchronised input levels of one GPIO bank. It turns selected conditions on each pin into sticky status bits. Each pin has three independent configuration bits. The edge-select bit chooses between edge and level sensing. The polarity bit chooses rising/high or falling/low. The both-edges bit, which applies only in edge mode, makes the pin react to either transition.

Software clears status bits by writing ones to them. Two strobe addresses adjust a per-pin mask. A write of ones to the unmask strobe clears the matching mask bits, and a write of ones to the mask strobe sets them. The mask only gates whether a pending bit reaches the single interrupt line. Detection and latching carry on while a pin is masked, so an event caught during that time is signalled as soon as the pin is unmasked.

The register port has a one-cycle write strobe and a read address. Read data appears registered on the next cycle. The register map, as byte addresses on a 5-bit address, is:

| Address | Register | Access |
|---|---|---|
| 0x00 | edge-select | read/write |
| 0x04 | polarity | read/write |
| 0x08 | both-edges | read/write |
| 0x0C | mask | read only |
| 0x10 | unmask strobe | write only, reads 0 |
| 0x14 | mask strobe | write only, reads 0 |
| 0x18 | status | read, write 1 to clear |

Top module: `gpio_event_detect`

## Requirements
- R1: After reset the mask reads 0xFFFFFFFF, and status, edge-select, polarity and both-edges all read 0. The interrupt output is 0.
- R2: With edge-select=1, polarity=1 and both-edges=0, a 0-to-1 change of a pin sets its status bit in the clock edge that first samples the new level. A 1-to-0 change sets nothing.
- R3: With edge-select=1, polarity=0 and both-edges=0, only a 1-to-0 change sets the status bit.
- R4: With edge-select=1 and both-edges=1, either change sets the status bit, whatever the polarity bit holds.
- R5: With edge-select=0, the status bit is set on every cycle that the pin equals its polarity bit (1 = high, 0 = low), so a clear does not hold while that level persists. The both-edges bit has no effect in this mode.
- R6: Writing the status address (0x18) clears exactly the bits written as 1; bits written as 0 keep their value. When a new event and a clear hit the same bit in the same cycle, the bit stays set.
- R7: A write to the unmask strobe (0x10) clears the mask bits written as 1, and a write to the mask strobe (0x14) sets them. Zero bits leave the mask unchanged, and writes to the mask address (0x0C) have no effect.
- R8: Events are latched into status while the pin is masked. Unmasking a pin with a pending bit raises the interrupt.
- R9: The interrupt output is 1 exactly when some status bit is 1 with its mask bit 0. It is registered and changes in the same clock edge as the status and mask values it reflects.
- R10: Read data for the address presented before a clock edge appears after that edge. The two strobe addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 32 | Synchronised pin levels |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 5 | Register byte address for writes |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Register byte address for reads |
| rd_data | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt, OR of unmasked pending bits |

## Verification
Six pins are configured in six different modes and then driven in both directions. Each mode is shown to react to its own transition or level and to ignore the opposite one. One pin carries the both-edges bit set with the polarity bit also set, which shows that polarity is ignored when both edges are selected. A second pin carries the both-edges bit in level mode, which shows that the bit is ignored there. Clears are issued with partial bit patterns, and once in the same cycle as a fresh edge, to separate per-bit clearing from set priority. An active level is held across a clear to show that the status bit is set again at once. Masked events followed by unmask writes, and a mask write on a live pending bit, show that the mask gates only the interrupt line.

// File: rtl/gpd_pkg.sv
package gpd_pkg;

  localparam int unsigned GPD_AW = 5;

  typedef enum logic [GPD_AW-1:0] {
    SEL_EDGE    = 5'h00,
    SEL_POL     = 5'h04,
    SEL_BOTH    = 5'h08,
    SEL_MASK    = 5'h0C,
    SEL_UNMASK  = 5'h10,
    SEL_MASKSET = 5'h14,
    SEL_STATUS  = 5'h18
  } gpd_reg_e;

  typedef struct packed {
    logic edge_we;
    logic pol_we;
    logic both_we;
    logic unm_we;
    logic msk_we;
    logic clr_we;
  } gpd_wr_s;

endpackage

// File: rtl/gpd_cfg_regs.sv
module gpd_cfg_regs
  import gpd_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  gpd_wr_s      wr,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] edge_q,
  output logic [N-1:0] pol_q,
  output logic [N-1:0] both_q,
  output logic [N-1:0] mask_q,
  output logic [N-1:0] mask_d
);

  always_comb begin
    mask_d = mask_q;
    if (wr.unm_we) mask_d = mask_q & ~wdata;
    if (wr.msk_we) mask_d = mask_q | wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      edge_q <= '0;
      pol_q  <= '0;
      both_q <= '0;
      mask_q <= '1;
    end else begin
      if (wr.edge_we) edge_q <= wdata;
      if (wr.pol_we)  pol_q  <= wdata;
      if (wr.both_we) both_q <= wdata;
      mask_q <= mask_d;
    end
  end

  // R7: the mask moves only on a strobe write
  a_r7_mask_only_strobes: assert property (@(posedge clk) disable iff (rst)
    !(wr.unm_we || wr.msk_we) |=> $stable(mask_q));

endmodule

// File: rtl/gpd_detect.sv
module gpd_detect #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_i,
  input  logic [N-1:0] edge_q,
  input  logic [N-1:0] pol_q,
  input  logic [N-1:0] both_q,
  output logic [N-1:0] evt
);

  // Previous level follows the pins during reset too, so release is quiet.
  logic [N-1:0] prev_q;

  always_ff @(posedge clk) begin
    prev_q <= pin_i;
  end

  for (genvar i = 0; i < N; i++) begin : g_pin
    logic rise, fall, edge_hit, lvl_hit;
    assign rise     = pin_i[i] & ~prev_q[i];
    assign fall     = ~pin_i[i] & prev_q[i];
    assign edge_hit = both_q[i] ? (rise | fall) : (pol_q[i] ? rise : fall);
    assign lvl_hit  = pol_q[i] ? pin_i[i] : ~pin_i[i];
    assign evt[i]   = edge_q[i] ? edge_hit : lvl_hit;
  end

  // R2: an edge-mode pin with an unchanged level never reports an event
  a_r2_edge_needs_change: assert property (@(posedge clk) disable iff (rst)
    ((evt & edge_q & ~(pin_i ^ prev_q)) == '0));

endmodule

// File: rtl/gpd_status.sv
module gpd_status #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt,
  input  logic         clr_we,
  input  logic [N-1:0] wdata,
  input  logic [N-1:0] mask_d,
  output logic [N-1:0] status_q,
  output logic         irq_q
);

  logic [N-1:0] clr_bits;
  logic [N-1:0] status_d;

  assign clr_bits = clr_we ? wdata : '0;
  assign status_d = (status_q & ~clr_bits) | evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      irq_q    <= |(status_d & ~mask_d);
    end
  end

  // R6: an event always lands, even against a clear of the same bit
  a_r6_event_wins: assert property (@(posedge clk) disable iff (rst)
    (|evt) |=> ((status_q & $past(evt)) == $past(evt)));

  // R6: a bit never rises without an event
  a_r6_no_spurious_set: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(evt)) == '0));

endmodule

// File: rtl/gpio_event_detect.sv
module gpio_event_detect
  import gpd_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      pin_i,
  input  logic              wr_en,
  input  logic [GPD_AW-1:0] wr_addr,
  input  logic [N-1:0]      wr_data,
  input  logic [GPD_AW-1:0] rd_addr,
  output logic [N-1:0]      rd_data,
  output logic              irq_o
);

  gpd_wr_s      wr;
  logic [N-1:0] edge_q, pol_q, both_q, mask_q, mask_d;
  logic [N-1:0] evt, status_q;

  always_comb begin
    wr = '0;
    if (wr_en) begin
      unique case (gpd_reg_e'(wr_addr))
        SEL_EDGE:    wr.edge_we = 1'b1;
        SEL_POL:     wr.pol_we  = 1'b1;
        SEL_BOTH:    wr.both_we = 1'b1;
        SEL_UNMASK:  wr.unm_we  = 1'b1;
        SEL_MASKSET: wr.msk_we  = 1'b1;
        SEL_STATUS:  wr.clr_we  = 1'b1;
        default:     ;
      endcase
    end
  end

  gpd_cfg_regs #(.N(N)) u_cfg (
    .clk(clk), .rst(rst), .wr(wr), .wdata(wr_data),
    .edge_q(edge_q), .pol_q(pol_q), .both_q(both_q),
    .mask_q(mask_q), .mask_d(mask_d)
  );

  gpd_detect #(.N(N)) u_det (
    .clk(clk), .rst(rst), .pin_i(pin_i),
    .edge_q(edge_q), .pol_q(pol_q), .both_q(both_q), .evt(evt)
  );

  gpd_status #(.N(N)) u_sts (
    .clk(clk), .rst(rst), .evt(evt), .clr_we(wr.clr_we), .wdata(wr_data),
    .mask_d(mask_d), .status_q(status_q), .irq_q(irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      unique case (gpd_reg_e'(rd_addr))
        SEL_EDGE:   rd_data <= edge_q;
        SEL_POL:    rd_data <= pol_q;
        SEL_BOTH:   rd_data <= both_q;
        SEL_MASK:   rd_data <= mask_q;
        SEL_STATUS: rd_data <= status_q;
        default:    rd_data <= '0;
      endcase
    end
  end

  // R9: interrupt tracks unmasked pending bits in the same edge
  a_r9_irq_matches: assert property (@(posedge clk) disable iff (rst)
    irq_o == |(status_q & ~mask_q));

endmodule

// File: tb/test_gpio_event_detect.sv
module test_gpio_event_detect;

  localparam logic [4:0] A_EDGE = 5'h00, A_POL = 5'h04, A_BOTH = 5'h08,
                         A_MASK = 5'h0C, A_UNM = 5'h10, A_MSET = 5'h14,
                         A_STS = 5'h18;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] pin_i;
  logic        wr_en;
  logic [4:0]  wr_addr;
  logic [31:0] wr_data;
  logic [4:0]  rd_addr;
  logic [31:0] rd_data;
  logic        irq_o;

  always #5 clk = ~clk;

  gpio_event_detect i_gpio_event_detect (
    .clk(clk), .rst(rst), .pin_i(pin_i), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o)
  );

  typedef struct {
    int          due;
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb_q[$];
  int    cyc = 0;
  int    n_run = 0;
  int    n_fail = 0;
  bit    finished = 0;
  logic [31:0] pv;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops expected items when their cycle arrives
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].due == cyc) begin
      item_t it;
      logic [31:0] act;
      it = sb_q.pop_front();
      act = it.is_irq ? {31'd0, irq_o} : rd_data;
      n_run++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic setp(input logic [31:0] v);
    pv = v; pin_i = v;
    @(negedge clk);
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string t);
    item_t it;
    rd_addr = a;
    it.due = cyc + 1; it.is_irq = 1'b0; it.exp = e; it.tag = t;
    sb_q.push_back(it);
    @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string t);
    item_t it;
    it.due = cyc + 1; it.is_irq = 1'b1; it.exp = {31'd0, e}; it.tag = t;
    sb_q.push_back(it);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; pv = 32'hFFFF_FFFF; pin_i = pv;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = A_EDGE;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(A_MASK, 32'hFFFF_FFFF, "R1 mask");
    rd(A_STS,  32'h0, "R1 status");
    rd(A_EDGE, 32'h0, "R1 edge");
    rd(A_POL,  32'h0, "R1 pol");
    rd(A_BOTH, 32'h0, "R1 both");
    chk_irq(1'b0, "R1 irq");

    // pins: 0 rise, 1 fall, 2 both(pol0), 3 both(pol1), 4 level high, 5 level low
    wr(A_EDGE, 32'h0000_000F);
    wr(A_BOTH, 32'h0000_001C);
    wr(A_POL,  32'h0000_0019);
    setp(32'hFFFF_FFEF);
    wr(A_STS, 32'hFFFF_FFFF);
    rd(A_EDGE, 32'h0000_000F, "R10 edge readback");
    rd(A_POL,  32'h0000_0019, "R10 pol readback");
    rd(A_BOTH, 32'h0000_001C, "R10 both readback");
    rd(A_STS,  32'h0, "R6 all cleared");

    // R2 rising only
    setp(pv & ~32'h1);
    rd(A_STS, 32'h0, "R2 falling ignored");
    setp(pv | 32'h1);
    rd(A_STS, 32'h1, "R2 rising sets");
    rd(A_STS, 32'h1, "R2 sticky");
    wr(A_STS, 32'h1);

    // R3 falling only
    setp(pv & ~32'h2);
    rd(A_STS, 32'h2, "R3 falling sets");
    wr(A_STS, 32'h2);
    setp(pv | 32'h2);
    rd(A_STS, 32'h0, "R3 rising ignored");

    // R4 both edges regardless of polarity
    setp(pv & ~32'hC);
    rd(A_STS, 32'hC, "R4 falling both");
    wr(A_STS, 32'hC);
    setp(pv | 32'hC);
    rd(A_STS, 32'hC, "R4 rising both");
    wr(A_STS, 32'hC);

    // R5 level modes (pin 4 also has both-edges set, which must not matter)
    setp(pv | 32'h10);
    rd(A_STS, 32'h10, "R5 level high sets");
    wr(A_STS, 32'h10);
    rd(A_STS, 32'h10, "R5 level persists over clear");
    setp(pv & ~32'h10);
    wr(A_STS, 32'h10);
    rd(A_STS, 32'h0, "R5 inactive level clears");
    setp(pv & ~32'h20);
    rd(A_STS, 32'h20, "R5 level low sets");
    setp(pv | 32'h20);
    wr(A_STS, 32'h20);
    rd(A_STS, 32'h0, "R5 level low released");

    // R6 partial clear and set priority
    setp(pv & ~32'h3);
    setp(pv | 32'h1);
    rd(A_STS, 32'h3, "R6 two pending");
    wr(A_STS, 32'h1);
    rd(A_STS, 32'h2, "R6 zero bits kept");
    setp(pv | 32'h2);
    wr(A_STS, 32'h2);
    setp(pv & ~32'h1);
    pv = pv | 32'h1; pin_i = pv;
    wr(A_STS, 32'h1);
    rd(A_STS, 32'h1, "R6 event beats clear");
    wr(A_STS, 32'hFFFF_FFFF);

    // R7 mask strobes
    wr(A_UNM, 32'h3);
    rd(A_MASK, 32'hFFFF_FFFC, "R7 unmask ones");
    wr(A_UNM, 32'h0);
    rd(A_MASK, 32'hFFFF_FFFC, "R7 unmask zeros");
    wr(A_MSET, 32'h1);
    rd(A_MASK, 32'hFFFF_FFFD, "R7 mask set");
    wr(A_MASK, 32'h0);
    rd(A_MASK, 32'hFFFF_FFFD, "R7 mask read-only");
    wr(A_MSET, 32'h0);
    rd(A_MASK, 32'hFFFF_FFFD, "R7 mask zeros");

    // R8 / R9 masked latching and interrupt
    chk_irq(1'b0, "R9 idle irq");
    setp(pv & ~32'h1);
    setp(pv | 32'h1);
    rd(A_STS, 32'h1, "R8 latched while masked");
    chk_irq(1'b0, "R8 masked no irq");
    wr(A_UNM, 32'h1);
    chk_irq(1'b1, "R8 irq on unmask");
    wr(A_STS, 32'h1);
    chk_irq(1'b0, "R9 irq drops on clear");
    setp(pv & ~32'h2);
    chk_irq(1'b1, "R9 unmasked event irq");
    wr(A_MSET, 32'h2);
    chk_irq(1'b0, "R9 irq drops on mask");
    rd(A_STS, 32'h2, "R8 status kept after mask");

    // R10 strobe addresses read zero
    rd(A_UNM,  32'h0, "R10 unmask reads 0");
    rd(A_MSET, 32'h0, "R10 mask strobe reads 0");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule